// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor's program sequencer and decides which of nine interrupt sources is serviced next. Each source has a fixed rank. The block keeps a pending state for every source and applies a software mask. It also takes set and clear requests through one write register, and it turns each of the three external request lines into either an edge-latched or a level-followed request. While at least one enabled request is allowed to run, it raises `irq_req` and presents the vector address of the highest-ranked one.

The sequencer answers with a one-cycle `ack`. That pulse puts the presented source into service and drops its pending latch. Later, a one-cycle `rti` retires the innermost service level. The control register decides what happens while a source is in service. With nesting off, nothing new is offered until `rti`. With nesting on, only a strictly higher-ranked source may interrupt the active one.

Software writes three registers through `wr_en`/`wr_sel`/`wr_data`. A write takes effect on the clock edge it is sampled on.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source index 0 is the highest rank and index 8 the lowest. The sources, with their vectors, are: 0 trip 0x002C, 1 peripheral line 0x0004, 2 sync 0x000C, 3 I/O 0x0008, 4 soft-1 0x0018, 5 soft-0 0x001C, 6 serial-tx 0x0020, 7 serial-rx 0x0024, 8 timer 0x0028. When several sources are eligible, `irq_src` and `irq_vec` show the lowest index. Every vector is a multiple of 4 below 0x0030.
- R2: `wr_sel`=0 loads the mask from `wr_data[10:0]`. Bit (10 − index) enables a source: trip 10, peripheral 9, sync 8, I/O 7, soft-1 6, soft-0 5, tx 4, rx 3, timer 2. A masked source never raises `irq_req`.
- R3: A write with `wr_sel`=1 acts on slot k, which is source index k+1 for k = 0..7. Bit k of `wr_data` clears that pending latch and bit 8+k sets it. If both bits are written in one write, the set wins. Trip (index 0) cannot be reached through this register.
- R4: The two software sources have no input pin. Soft-1 is raised only by `wr_data[11]` and soft-0 only by `wr_data[12]` in a `wr_sel`=1 write.
- R5: `wr_sel`=2 loads the control register. Bits 0, 1 and 2 select the mode of `ext_n[0]` (rx), `ext_n[1]` (tx) and `ext_n[2]` (peripheral). A 1 selects edge mode: a high-to-low transition between two clock samples latches the request, and it is visible in the cycle after the sample that shows the low.
- R6: With a mode bit at 0 (level mode, also the reset value), the line is pending exactly while it is low. This takes effect combinationally, and the line leaves no latch behind when it returns high.
- R7: An `ack` while `irq_req` is high puts the presented source in service and clears its pending latch. An `ack` while `irq_req` is low has no effect.
- R8: With control bit 4 at 0, `irq_req` stays low while any source is in service. `rti` retires the most recent, highest-ranked service level.
- R9: With control bit 4 at 1, a request is offered only if its index is strictly lower than that of every source in service.
- R10: After reset the mask and control register are 0, nothing is pending or in service, and `irq_req`, `irq_vec` and `irq_src` are 0.
- R11: A high level on `evt[0]` (trip), `evt[1]` (sync), `evt[2]` (I/O) or `evt[3]` (timer) during a clock edge latches that source's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 mask, 1 set/clear, 2 control, 3 no register |
| wr_data | input | 16 | Write data |
| ext_n | input | 3 | Active-low external request lines (rx, tx, peripheral) |
| evt | input | 4 | Internal event requests (trip, sync, I/O, timer) |
| ack | input | 1 | Sequencer has taken the presented interrupt |
| rti | input | 1 | Return from the current service routine |
| irq_req | output | 1 | An allowed, enabled request is pending |
| irq_vec | output | 16 | Vector address of the presented source, 0 when idle |
| irq_src | output | 4 | Index of the presented source, 0 when idle |

## Verification
The bench attacks these corner cases:
- A set and a clear of the same slot in one write. A design that applied them in the other order would lose the request.
- An edge-mode line checked in the very cycle it falls, where a design that skipped the latch stage would answer one cycle early.
- A level line after it returns high, where a stray latch would leave a phantom request.
- Nesting with a lower-ranked source arriving during a higher one's service, which a design comparing "less or equal" or ignoring the outer level would take too early.
- Acknowledges while idle, which must not create an empty service level that blocks later requests.
- A mask-bit mapping that is off by one, which shows up as the wrong source being presented.

// File: rtl/ivc_pkg.sv
// Package: shared constants and helpers of the interrupt controller.
// Assumes source index 0 is the highest rank; all maps below are fixed.
package ivc_pkg;
    localparam int N_SRC  = 9;
    localparam int IDX_W  = $clog2(N_SRC + 1);
    localparam int N_EXT  = 3;
    localparam int N_EVT  = 4;
    localparam int N_SLOT = 8;
    localparam int DATA_W = 2 * N_SLOT;
    localparam int MASK_W = N_SRC + 2;
    localparam int MASK_TOP = MASK_W - 1;
    localparam int VEC_W  = 16;
    localparam int CTL_NEST = 4;

    // source index driven by each external line and each event input
    localparam int EXT_IDX [N_EXT] = '{7, 6, 1};
    localparam int EVT_IDX [N_EVT] = '{0, 2, 3, 8};

    // vector address of a source index
    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [VEC_W-1:0] v;
        case (idx)
            4'd0:    v = 16'h002C;
            4'd1:    v = 16'h0004;
            4'd2:    v = 16'h000C;
            4'd3:    v = 16'h0008;
            4'd4:    v = 16'h0018;
            4'd5:    v = 16'h001C;
            4'd6:    v = 16'h0020;
            4'd7:    v = 16'h0024;
            4'd8:    v = 16'h0028;
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/irq_pend.sv
// Pending state for all sources: edge latches, live level requests,
// software set/clear and acknowledge clearing.
// Assumes ack_hot is one-hot or zero and points at a pending source.
module irq_pend
    import ivc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_n,
    input  logic [N_EXT-1:0]  edge_sel,
    input  logic [N_EVT-1:0]  evt,
    input  logic [N_SLOT-1:0] clr_slot,
    input  logic [N_SLOT-1:0] frc_slot,
    input  logic [N_SRC-1:0]  ack_hot,
    output logic [N_SRC-1:0]  pend
);
    logic [N_SRC-1:0] latch_q;
    logic [N_EXT-1:0] prev_q;
    logic [N_SRC-1:0] set_v;
    logic [N_SRC-1:0] clr_v;
    logic [N_SRC-1:0] live_v;

    // gather set, clear and live-level terms per source index
    always_comb begin
        set_v  = '0;
        clr_v  = '0;
        live_v = '0;
        for (int j = 0; j < N_EXT; j++) begin
            set_v[EXT_IDX[j]]  = edge_sel[j] & prev_q[j] & ~ext_n[j];
            live_v[EXT_IDX[j]] = ~edge_sel[j] & ~ext_n[j];
        end
        for (int e = 0; e < N_EVT; e++) begin
            set_v[EVT_IDX[e]] = set_v[EVT_IDX[e]] | evt[e];
        end
        for (int k = 0; k < N_SLOT; k++) begin
            set_v[k+1] = set_v[k+1] | frc_slot[k];
            clr_v[k+1] = clr_slot[k];
        end
    end

    // pending latches: clears first, sets win
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q & ~clr_v & ~ack_hot) | set_v;
    end

    // previous line samples for falling-edge detection (idle high)
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= ext_n;
    end

    // a source is pending if latched or if its level line is low
    always_comb pend = latch_q | live_v;

    // R7: the resolver only ever acknowledges one pending source
    p_ack_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hot) && ((ack_hot & ~pend) == '0));

    // R11: an event seen on an edge is pending on the next cycle
    p_evt_latched_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> pend[0]);
endmodule

// File: rtl/irq_svc.sv
// In-service tracking: one bit per source in service, retire on return,
// and the set of ranks allowed to be offered under the nesting setting.
// Assumes take is only raised for a source that was allowed.
module irq_svc
    import ivc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nest_en,
    input  logic             take,
    input  logic [IDX_W-1:0] take_src,
    input  logic             rti,
    output logic [N_SRC-1:0] allow
);
    logic [N_SRC-1:0] act_q;
    logic [N_SRC-1:0] act_nx;
    logic [IDX_W-1:0] level;

    // rank of the innermost (highest-ranked) active service level
    always_comb begin
        level = IDX_W'(N_SRC);
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (act_q[i]) level = IDX_W'(i);
        end
    end

    // ranks eligible to be offered now
    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            if (act_q == '0) allow[i] = 1'b1;
            else             allow[i] = nest_en && (IDX_W'(i) < level);
        end
    end

    // next service set: retire innermost, then add the taken source
    always_comb begin
        act_nx = act_q;
        if (rti && (level < IDX_W'(N_SRC))) act_nx[level] = 1'b0;
        if (take) act_nx[take_src] = 1'b1;
    end

    // service register
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_nx;
    end

    // R8: nothing is taken on top of an active level without nesting
    p_no_take_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (act_q != '0)) |-> nest_en);

    // R9: a preempting source outranks every active one
    p_strict_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (act_q != '0)) |-> (take_src < level));

    // R8: a return with nothing taken retires exactly one level
    p_rti_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && !take && (act_q != '0)) |=>
            ($countones(act_q) == $countones($past(act_q)) - 1));
endmodule

// File: rtl/irq_sel.sv
// Priority resolver: picks the lowest eligible index and its vector.
// Assumes pend, en and allow are aligned by source index.
module irq_sel
    import ivc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] allow,
    output logic             req,
    output logic [IDX_W-1:0] src,
    output logic [VEC_W-1:0] vec
);
    logic [N_SRC-1:0] cand;

    // eligible sources
    always_comb cand = pend & en & allow;

    // scan from lowest rank upward so the highest rank wins
    always_comb begin
        req = 1'b0;
        src = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                req = 1'b1;
                src = IDX_W'(i);
            end
        end
        vec = req ? vec_of(src) : '0;
    end

    // R1: presented vectors are word-slot aligned inside the table
    p_vec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ((vec[1:0] == 2'b00) && (vec < 16'h0030) && (vec != '0)));

    // R10: the outputs are quiet when nothing is offered
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> ((vec == '0) && (src == '0)));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: register file (mask, control), set/clear decode, and the link
// between pending state, resolver and service tracking.
// Assumes ack and rti are single-cycle strobes from the sequencer.
module prio_irq_ctrl
    import ivc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_EXT-1:0]  ext_n,
    input  logic [N_EVT-1:0]  evt,
    input  logic              ack,
    input  logic              rti,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [IDX_W-1:0]  irq_src
);
    logic [MASK_W-1:0] mask_q;
    logic [N_EXT-1:0]  edge_q;
    logic              nest_q;
    logic [N_SLOT-1:0] clr_slot;
    logic [N_SLOT-1:0] frc_slot;
    logic [N_SRC-1:0]  en;
    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  allow;
    logic [N_SRC-1:0]  ack_hot;
    logic              take;

    // mask register
    always_ff @(posedge clk) begin
        if (!rst_n)                      mask_q <= '0;
        else if (wr_en && wr_sel == 2'd0) mask_q <= wr_data[MASK_W-1:0];
    end

    // control register: sensitivity bits and nesting enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
            nest_q <= 1'b0;
        end else if (wr_en && wr_sel == 2'd2) begin
            edge_q <= wr_data[N_EXT-1:0];
            nest_q <= wr_data[CTL_NEST];
        end
    end

    // set/clear halves of the one-shot register
    always_comb begin
        clr_slot = (wr_en && wr_sel == 2'd1) ? wr_data[N_SLOT-1:0] : '0;
        frc_slot = (wr_en && wr_sel == 2'd1) ? wr_data[DATA_W-1:N_SLOT] : '0;
    end

    // mask bit (MASK_TOP - index) enables each source
    for (genvar g = 0; g < N_SRC; g++) begin : g_en
        assign en[g] = mask_q[MASK_TOP - g];
    end

    // accepted acknowledge, one-hot on the presented source
    always_comb begin
        take    = ack && irq_req;
        ack_hot = '0;
        if (take) ack_hot[irq_src] = 1'b1;
    end

    irq_pend u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_n    (ext_n),
        .edge_sel (edge_q),
        .evt      (evt),
        .clr_slot (clr_slot),
        .frc_slot (frc_slot),
        .ack_hot  (ack_hot),
        .pend     (pend)
    );

    irq_svc u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .nest_en  (nest_q),
        .take     (take),
        .take_src (irq_src),
        .rti      (rti),
        .allow    (allow)
    );

    irq_sel u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .en    (en),
        .allow (allow),
        .req   (irq_req),
        .src   (irq_src),
        .vec   (irq_vec)
    );

    // R2: a presented source always has its mask bit set
    p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> mask_q[MASK_TOP - int'(irq_src)]);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = '0;
    logic [2:0]  ext_n = 3'b111;
    logic [3:0]  evt = '0;
    logic        ack = 1'b0;
    logic        rti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [3:0]  irq_src;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ext_n(ext_n), .evt(evt), .ack(ack), .rti(rti),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_src(irq_src)
    );

    // behavioural reference state
    bit m_lat [9];
    bit m_act [9];
    bit m_prev [3];
    bit [10:0] m_mask;
    bit [2:0]  m_edge;
    bit        m_nest;

    function automatic int vec_ref(int i);
        int t [9] = '{'h2C, 'h04, 'h0C, 'h08, 'h18, 'h1C, 'h20, 'h24, 'h28};
        return t[i];
    endfunction

    function automatic int ext_src(int j);
        return (j == 0) ? 7 : (j == 1) ? 6 : 1;
    endfunction

    // reference choice: -1 when nothing is offered
    function automatic int m_pick();
        int lvl = 9;
        int any = 0;
        for (int i = 8; i >= 0; i--) if (m_act[i]) begin lvl = i; any = 1; end
        for (int i = 0; i < 9; i++) begin
            bit p = m_lat[i];
            bit ok;
            for (int j = 0; j < 3; j++)
                if (ext_src(j) == i && !m_edge[j] && !ext_n[j]) p = 1;
            ok = (any == 0) || (m_nest && i < lvl);
            if (p && m_mask[10 - i] && ok) return i;
        end
        return -1;
    endfunction

    task automatic check(string req, int act_v, int exp_v);
        tests++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    // reference update on each edge, compare shortly after it
    always @(posedge clk) begin
        int pick;
        int ev_src [4] = '{0, 2, 3, 8};
        bit setb [9];
        bit clrb [9];
        pick = m_pick();
        if (!rst_n) begin
            for (int i = 0; i < 9; i++) begin m_lat[i] = 0; m_act[i] = 0; end
            for (int j = 0; j < 3; j++) m_prev[j] = 1;
            m_mask = 0; m_edge = 0; m_nest = 0;
        end else begin
            for (int i = 0; i < 9; i++) begin setb[i] = 0; clrb[i] = 0; end
            for (int e = 0; e < 4; e++) if (evt[e]) setb[ev_src[e]] = 1;
            for (int j = 0; j < 3; j++)
                if (m_edge[j] && m_prev[j] && !ext_n[j]) setb[ext_src(j)] = 1;
            if (wr_en && wr_sel == 1)
                for (int k = 0; k < 8; k++) begin
                    if (wr_data[k])     clrb[k+1] = 1;
                    if (wr_data[k + 8]) setb[k+1] = 1;
                end
            if (ack && pick >= 0) clrb[pick] = 1;
            for (int i = 0; i < 9; i++) m_lat[i] = (m_lat[i] && !clrb[i]) || setb[i];
            if (rti) begin
                for (int i = 0; i < 9; i++) if (m_act[i]) begin m_act[i] = 0; break; end
            end
            if (ack && pick >= 0) m_act[pick] = 1;
            for (int j = 0; j < 3; j++) m_prev[j] = ext_n[j];
            if (wr_en && wr_sel == 0) m_mask = wr_data[10:0];
            if (wr_en && wr_sel == 2) begin m_edge = wr_data[2:0]; m_nest = wr_data[4]; end
        end
        #1;
        pick = m_pick();
        check("R1 model req", int'(irq_req), int'(pick >= 0));
        check("R1 model vec", int'(irq_vec), (pick >= 0) ? vec_ref(pick) : 0);
        check("R1 model src", int'(irq_src), (pick >= 0) ? pick : 0);
    end

    task automatic wr(int sel, int data);
        @(negedge clk); wr_en = 1; wr_sel = 2'(sel); wr_data = 16'(data);
        @(negedge clk); wr_en = 0; wr_data = 0;
        #1;
    endtask

    task automatic ackp();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
        #1;
    endtask

    task automatic rtip();
        @(negedge clk); rti = 1;
        @(negedge clk); rti = 0;
        #1;
    endtask

    task automatic expect_out(string req, int r, int v);
        check(req, int'(irq_req), r);
        check(req, int'(irq_vec), v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        expect_out("R10 reset", 0, 0);
        check("R10 reset src", int'(irq_src), 0);

        wr(0, 'h07FC);
        wr(1, 1 << 12);
        expect_out("R4 soft0 forced", 1, 'h1C);
        wr(1, 1 << 11);
        expect_out("R1 soft1 outranks soft0", 1, 'h18);
        check("R1 src", int'(irq_src), 4);
        wr(1, 'h0018);
        expect_out("R3 clear both", 0, 0);

        wr(0, 'h07F8);
        wr(1, 1 << 15);
        expect_out("R2 timer masked", 0, 0);
        wr(0, 'h07FC);
        expect_out("R2 timer enabled", 1, 'h28);

        ackp();
        expect_out("R7 taken timer", 0, 0);
        wr(1, 1 << 12);
        expect_out("R8 blocked while busy", 0, 0);
        rtip();
        expect_out("R8 offered after return", 1, 'h1C);
        ackp();
        rtip();
        expect_out("R7 ack cleared latch", 0, 0);

        @(negedge clk); ext_n = 3'b110; #1;
        expect_out("R6 level low", 1, 'h24);
        @(negedge clk); ext_n = 3'b111; #1;
        expect_out("R6 level released", 0, 0);

        wr(2, 'h0001);
        @(negedge clk); ext_n = 3'b110; #1;
        expect_out("R5 edge not yet latched", 0, 0);
        @(negedge clk); ext_n = 3'b111; #1;
        expect_out("R5 edge latched", 1, 'h24);
        ackp();
        rtip();
        expect_out("R7 edge latch cleared", 0, 0);

        wr(2, 'h0010);
        wr(1, 1 << 15);
        ackp();
        expect_out("R9 nothing outranks", 0, 0);
        wr(1, 1 << 12);
        expect_out("R9 higher preempts", 1, 'h1C);
        ackp();
        wr(1, 1 << 13);
        expect_out("R9 lower waits", 0, 0);
        rtip();
        expect_out("R9 tx above timer", 1, 'h20);
        ackp();
        rtip();
        rtip();
        expect_out("R9 all retired", 0, 0);

        @(negedge clk); evt = 4'b0001;
        @(negedge clk); evt = 4'b0000; #1;
        expect_out("R11 trip latched", 1, 'h2C);
        check("R11 trip src", int'(irq_src), 0);
        wr(1, 'h00FF);
        expect_out("R3 trip not clearable", 1, 'h2C);
        ackp();
        rtip();
        expect_out("R7 trip acked", 0, 0);

        ackp();
        wr(2, 'h0000);
        wr(1, 1 << 12);
        expect_out("R7 idle ack ignored", 1, 'h1C);
        wr(1, 'h0010);
        expect_out("R3 cleared soft0", 0, 0);
        wr(1, 'h1010);
        expect_out("R3 set wins", 1, 'h1C);
        wr(1, 'h0010);

        wr(0, 'h0200);
        @(negedge clk); ext_n = 3'b010; #1;
        expect_out("R2 peripheral bit 9", 1, 'h04);
        check("R2 peripheral src", int'(irq_src), 1);
        wr(0, 'h0008);
        expect_out("R2 rx bit 3", 1, 'h24);
        @(negedge clk); ext_n = 3'b111; #1;
        expect_out("R6 lines released", 0, 0);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule